// File: doc/BRIEF.md
# DMA Peripheral Port Allocator

This block decides which DMA channel serves which peripheral port. There are ten channels and twenty ports. Ten of the ports carry transmit traffic and ten carry receive traffic. Each channel has a small allocation register, reached over a simple register write and read interface. The register names one port index within the channel's direction.

When a channel is enabled, the block takes a snapshot of its allocation and its direction. From then on it steers that port's request line to the channel, and it steers the channel's acknowledge back to the port. Two enabled channels of the same direction may name the same port. In that case the lower-numbered channel keeps the port and the other channel is left without one.

The channel state machines and the data path sit outside this block. They supply the enables, the directions and the acknowledges. Software writes the allocation before it enables a channel. A register that was never written keeps its reset mapping, which is channel n to port n.

Top module: `dma_port_alloc`

## Requirements
- R1: After reset, every allocation register reads back its own channel number, and ch_req_o, tx_ack_o and rx_ack_o are all 0.
- R2: The allocation register of channel n sits at byte address n*64 + 8. A write stores wdata[3:0], and a read returns that value in bits [3:0] with bits [31:4] at 0. Writes to any other offset, or to a channel index of 10 or more, change no register.
- R3: Selection values 0 to 9 pick the port with that index, and values 10 to 15 pick no port. A channel with no port keeps ch_req_o at 0 whatever the request inputs do.
- R4: The selection and the direction are captured on the clock edge that first samples ch_en_i high. Routing starts in the cycle after that edge, so ch_req_o stays 0 in the cycle in which the enable rises. Writes made while the channel is enabled change only the readback value until the channel is enabled again.
- R5: ch_dir_i selects the direction: 0 means transmit and 1 means receive. An enabled channel that owns port p drives ch_req_o with tx_req_i[p] (transmit) or rx_req_i[p] (receive).
- R6: A port owned by an enabled channel outputs that channel's ch_ack_i bit on its tx_ack_o or rx_ack_o line.
- R7: When several enabled channels of one direction select the same port, the lowest-numbered one owns it. The others keep ch_req_o at 0, and their ch_ack_i bits do not reach any port.
- R8: A port with no owner holds its acknowledge at 0. A channel whose enable is low drives ch_req_o at 0.
- R9: With the reset allocations, enabling channel n maps it to port n of its direction.
- R10: A transmit channel and a receive channel that select the same index do not conflict. Each one owns the port of its own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| ch_en_i | input | 10 | Channel enables |
| ch_dir_i | input | 10 | Channel direction, 0 transmit, 1 receive |
| ch_ack_i | input | 10 | Acknowledge from each channel |
| ch_req_o | output | 10 | Request routed to each channel |
| tx_req_i | input | 10 | Transmit port requests |
| tx_ack_o | output | 10 | Transmit port acknowledges |
| rx_req_i | input | 10 | Receive port requests |
| rx_ack_o | output | 10 | Receive port acknowledges |

## Verification
The assertions hold on every cycle for the following properties:
- the reserved read bits stay at 0;
- a disabled channel and the first cycle of an enable give no request;
- idle inputs give idle outputs;
- no more port acknowledges are raised than there are enabled, acknowledging channels.

Some behaviour can only be shown by the bench's scenarios. That covers which port a channel owns after a write and a re-enable, and the fact that a write made while the channel is enabled is ignored. It also covers the lowest-channel priority in a conflict, the no-port encodings, and the separation of transmit and receive. The bench compares each of these against its own ownership model.

// File: rtl/dma_port_alloc_pkg.sv
package dma_port_alloc_pkg;
  localparam int SEL_W    = 4;
  localparam int REG_W    = 32;
  localparam int CH_SHIFT = 6;
  localparam logic [CH_SHIFT-1:0] SEL_OFS = 6'h08;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/alloc_regs.sv
module alloc_regs
  import dma_port_alloc_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int ADDR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [SEL_W-1:0] sel_o [NUM_CH]
);
  localparam int IDX_W = ADDR_W - CH_SHIFT;

  logic [IDX_W-1:0] idx;
  logic             hit;

  assign idx = addr_i[ADDR_W-1:CH_SHIFT];
  assign hit = (addr_i[CH_SHIFT-1:0] == SEL_OFS) && (int'(idx) < NUM_CH);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_reg
    logic [SEL_W-1:0] sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          sel_q <= SEL_W'(n);
      else if (we_i && hit && int'(idx) == n) sel_q <= wdata_i[SEL_W-1:0];
    end
    assign sel_o[n] = sel_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (hit && int'(idx) == n) rdata_o[SEL_W-1:0] = sel_o[n];
  end
endmodule

// File: rtl/alloc_snap.sv
module alloc_snap
  import dma_port_alloc_pkg::*;
#(
  parameter int NUM_CH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] dir_i,
  input  logic [SEL_W-1:0] sel_i [NUM_CH],
  output logic [NUM_CH-1:0] act_o,
  output logic [SEL_W-1:0] sel_o [NUM_CH],
  output dir_e             dir_o [NUM_CH]
);
  logic [NUM_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_i;
  end

  // snapshot taken on the enable's first sampled-high edge
  for (genvar n = 0; n < NUM_CH; n++) begin : g_snap
    logic [SEL_W-1:0] sel_q;
    dir_e             dir_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q <= SEL_W'(n);
        dir_q <= DIR_TX;
      end else if (en_i[n] && !en_q[n]) begin
        sel_q <= sel_i[n];
        dir_q <= dir_e'(dir_i[n]);
      end
    end
    assign sel_o[n] = sel_q;
    assign dir_o[n] = dir_q;
  end

  assign act_o = en_i & en_q;
endmodule

// File: rtl/port_arb.sv
module port_arb
  import dma_port_alloc_pkg::*;
#(
  parameter int   NUM_CH   = 10,
  parameter int   NUM_PORT = 10,
  parameter dir_e DIR      = DIR_TX,
  localparam int  CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]   act_i,
  input  logic [SEL_W-1:0]    sel_i [NUM_CH],
  input  dir_e                dir_i [NUM_CH],
  output logic [NUM_PORT-1:0] own_o,
  output logic [CH_W-1:0]     owner_o [NUM_PORT],
  output logic [NUM_CH-1:0]   grant_o
);
  // descending scan: the lowest channel is assigned last and wins
  always_comb begin
    for (int p = 0; p < NUM_PORT; p++) begin
      own_o[p]   = 1'b0;
      owner_o[p] = '0;
      for (int n = NUM_CH - 1; n >= 0; n--) begin
        if (act_i[n] && dir_i[n] == DIR && int'(sel_i[n]) == p) begin
          own_o[p]   = 1'b1;
          owner_o[p] = CH_W'(n);
        end
      end
    end
  end

  always_comb begin
    grant_o = '0;
    for (int n = 0; n < NUM_CH; n++)
      for (int p = 0; p < NUM_PORT; p++)
        if (act_i[n] && dir_i[n] == DIR && int'(sel_i[n]) == p &&
            own_o[p] && int'(owner_o[p]) == n)
          grant_o[n] = 1'b1;
  end
endmodule

// File: rtl/dma_port_alloc.sv
module dma_port_alloc
  import dma_port_alloc_pkg::*;
#(
  parameter int NUM_CH   = 10,
  parameter int NUM_PORT = 10,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_CH-1:0]   ch_en_i,
  input  logic [NUM_CH-1:0]   ch_dir_i,
  input  logic [NUM_CH-1:0]   ch_ack_i,
  output logic [NUM_CH-1:0]   ch_req_o,
  input  logic [NUM_PORT-1:0] tx_req_i,
  output logic [NUM_PORT-1:0] tx_ack_o,
  input  logic [NUM_PORT-1:0] rx_req_i,
  output logic [NUM_PORT-1:0] rx_ack_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [SEL_W-1:0]    reg_sel [NUM_CH];
  logic [SEL_W-1:0]    eff_sel [NUM_CH];
  dir_e                eff_dir [NUM_CH];
  logic [NUM_CH-1:0]   act;
  logic [NUM_PORT-1:0] tx_own, rx_own;
  logic [CH_W-1:0]     tx_owner [NUM_PORT];
  logic [CH_W-1:0]     rx_owner [NUM_PORT];
  logic [NUM_CH-1:0]   tx_grant, rx_grant;

  alloc_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .sel_o   (reg_sel)
  );

  alloc_snap #(.NUM_CH(NUM_CH)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ch_en_i),
    .dir_i  (ch_dir_i),
    .sel_i  (reg_sel),
    .act_o  (act),
    .sel_o  (eff_sel),
    .dir_o  (eff_dir)
  );

  port_arb #(.NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .DIR(DIR_TX)) u_arb_tx (
    .act_i   (act),
    .sel_i   (eff_sel),
    .dir_i   (eff_dir),
    .own_o   (tx_own),
    .owner_o (tx_owner),
    .grant_o (tx_grant)
  );

  port_arb #(.NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .DIR(DIR_RX)) u_arb_rx (
    .act_i   (act),
    .sel_i   (eff_sel),
    .dir_i   (eff_dir),
    .own_o   (rx_own),
    .owner_o (rx_owner),
    .grant_o (rx_grant)
  );

  always_comb begin
    ch_req_o = '0;
    for (int n = 0; n < NUM_CH; n++)
      for (int p = 0; p < NUM_PORT; p++)
        if (int'(eff_sel[n]) == p) begin
          if (tx_grant[n]) ch_req_o[n] = tx_req_i[p];
          if (rx_grant[n]) ch_req_o[n] = rx_req_i[p];
        end
  end

  always_comb begin
    tx_ack_o = '0;
    rx_ack_o = '0;
    for (int p = 0; p < NUM_PORT; p++) begin
      if (tx_own[p]) tx_ack_o[p] = ch_ack_i[tx_owner[p]];
      if (rx_own[p]) rx_ack_o[p] = ch_ack_i[rx_owner[p]];
    end
  end
endmodule

// File: rtl/dma_port_alloc_chk.sv
module dma_port_alloc_chk #(
  parameter int NUM_CH   = 10,
  parameter int NUM_PORT = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [31:0]         reg_rdata_o,
  input logic [NUM_CH-1:0]   ch_en_i,
  input logic [NUM_CH-1:0]   ch_ack_i,
  input logic [NUM_CH-1:0]   ch_req_o,
  input logic [NUM_PORT-1:0] tx_req_i,
  input logic [NUM_PORT-1:0] rx_req_i,
  input logic [NUM_PORT-1:0] tx_ack_o,
  input logic [NUM_PORT-1:0] rx_ack_o
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:4] == '0);

  // R8
  off_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o & ~ch_en_i) == '0);

  // R5
  idle_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i == '0 && rx_req_i == '0) |-> ch_req_o == '0);

  // R6
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ack_i == '0) |-> (tx_ack_o == '0 && rx_ack_o == '0));

  // R7
  ack_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tx_ack_o, rx_ack_o}) <= $countones(ch_ack_i & ch_en_i));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // R4
    first_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ch_en_i[n]) |-> !ch_req_o[n]);
  end
endmodule

bind dma_port_alloc dma_port_alloc_chk #(.NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rdata_o (reg_rdata_o),
  .ch_en_i     (ch_en_i),
  .ch_ack_i    (ch_ack_i),
  .ch_req_o    (ch_req_o),
  .tx_req_i    (tx_req_i),
  .rx_req_i    (rx_req_i),
  .tx_ack_o    (tx_ack_o),
  .rx_ack_o    (rx_ack_o)
);

// File: tb/dma_port_alloc_bench.sv
module dma_port_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;
  localparam int NP  = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [9:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [NCH-1:0] ch_en_i = '0, ch_dir_i = '0, ch_ack_i = '0, ch_req_o;
  logic [NP-1:0]  tx_req_i = '0, rx_req_i = '0, tx_ack_o, rx_ack_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_reg [NCH];
  int m_sel [NCH];
  bit m_dir [NCH];
  bit m_act [NCH];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dma_port_alloc u_dma_port_alloc (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .ch_en_i, .ch_dir_i, .ch_ack_i, .ch_req_o,
    .tx_req_i, .tx_ack_o, .rx_req_i, .rx_ack_o
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int ofs, logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i  = 10'(ch * 64 + ofs);
    reg_wdata_i = d;
    reg_we_i    = 1'b1;
    @(negedge clk_i);
    reg_we_i    = 1'b0;
    if (ch < NCH && ofs == 8) m_reg[ch] = int'(d[3:0]);
  endtask

  task automatic rd_check(string tag, int ch, logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = 10'(ch * 64 + 8);
    #1 check_eq(tag, reg_rdata_o, exp);
  endtask

  task automatic set_en(logic [NCH-1:0] mask);
    @(negedge clk_i);
    for (int n = 0; n < NCH; n++)
      if (mask[n] && !ch_en_i[n]) begin
        m_sel[n] = m_reg[n];
        m_dir[n] = ch_dir_i[n];
      end
    ch_en_i = mask;
    @(posedge clk_i);
    for (int n = 0; n < NCH; n++) m_act[n] = mask[n];
  endtask

  // reference ownership model built from R3, R5-R8, R10
  task automatic probe(string tag);
    int own_tx [NP];
    int own_rx [NP];
    logic [NCH-1:0] e_req;
    logic [NP-1:0]  e_tx, e_rx;
    #1;
    for (int p = 0; p < NP; p++) begin own_tx[p] = -1; own_rx[p] = -1; end
    for (int n = NCH - 1; n >= 0; n--)
      if (m_act[n] && m_sel[n] < NP) begin
        if (m_dir[n]) own_rx[m_sel[n]] = n;
        else          own_tx[m_sel[n]] = n;
      end
    e_req = '0;
    for (int n = 0; n < NCH; n++)
      if (m_act[n] && m_sel[n] < NP) begin
        if (!m_dir[n] && own_tx[m_sel[n]] == n) e_req[n] = tx_req_i[m_sel[n]];
        if (m_dir[n]  && own_rx[m_sel[n]] == n) e_req[n] = rx_req_i[m_sel[n]];
      end
    for (int p = 0; p < NP; p++) begin
      e_tx[p] = (own_tx[p] >= 0) ? ch_ack_i[own_tx[p]] : 1'b0;
      e_rx[p] = (own_rx[p] >= 0) ? ch_ack_i[own_rx[p]] : 1'b0;
    end
    check_eq({tag, " ch_req"}, 32'(ch_req_o), 32'(e_req));
    check_eq({tag, " tx_ack"}, 32'(tx_ack_o), 32'(e_tx));
    check_eq({tag, " rx_ack"}, 32'(rx_ack_o), 32'(e_rx));
  endtask

  task automatic drive(logic [NP-1:0] tq, logic [NP-1:0] rq, logic [NCH-1:0] ak);
    @(negedge clk_i);
    tx_req_i = tq; rx_req_i = rq; ch_ack_i = ak;
  endtask

  task automatic t_reset();
    drive('1, '1, '1);
    probe("R1 reset outputs");
    for (int n = 0; n < NCH; n++) rd_check("R1 reset readback", n, 32'(n));
    drive('0, '0, '0);
  endtask

  task automatic t_default();
    set_en('1);
    drive(10'h001, 10'h0, 10'h200); probe("R9 default map a");
    drive(10'h2A5, 10'h3FF, 10'h155); probe("R9 R5 R6 default map b");
    drive(10'h35A, 10'h0, 10'h2AA); probe("R6 default map c");
    set_en('0);
    drive('1, '1, '1); probe("R8 all disabled");
  endtask

  task automatic t_regs();
    wr(3, 8, 32'hFFFF_FFF7);
    rd_check("R2 reserved bits", 3, 32'h7);
    wr(3, 12, 32'h0000_0002);
    rd_check("R2 other offset ignored", 3, 32'h7);
    wr(12, 8, 32'h0000_0001);
    for (int n = 0; n < NCH; n++)
      rd_check("R2 out of range channel", n, (n == 3) ? 32'h7 : 32'(n));
    wr(3, 8, 32'h3);
  endtask

  task automatic t_latch();
    set_en('1);
    wr(0, 8, 32'h5);
    rd_check("R4 readback while enabled", 0, 32'h5);
    drive(10'h001, 10'h0, 10'h001); probe("R4 write held off");
    check_eq("R4 ch0 still on port0", 32'(ch_req_o[0]), 32'h1);
    set_en(10'h3FE);
    // rising cycle: no routing before the snapshot edge
    @(negedge clk_i);
    tx_req_i = '1;
    ch_en_i = '1;
    m_sel[0] = m_reg[0]; m_dir[0] = ch_dir_i[0];
    #1 check_eq("R4 rising cycle quiet", 32'(ch_req_o[0]), 32'h0);
    @(posedge clk_i);
    m_act[0] = 1'b1;
    drive(10'h020, 10'h0, 10'h020); probe("R7 loser ack blocked");
    check_eq("R7 ch0 wins port5", 32'(ch_req_o), 32'h001);
    drive(10'h001, 10'h0, 10'h001); probe("R8 port0 unowned");
    check_eq("R7 port5 follows ch0", 32'(tx_ack_o), 32'h020);
    drive('1, '0, '1); probe("R7 full load");
  endtask

  task automatic t_none();
    wr(2, 8, 32'hC);
    set_en(10'h3FB);
    set_en('1);
    drive('1, '1, '1); probe("R3 no port");
    check_eq("R3 ch2 req low", 32'(ch_req_o[2]), 32'h0);
    wr(6, 8, 32'hF);
    set_en(10'h3BF);
    set_en('1);
    drive('1, '1, '1); probe("R3 value 15");
  endtask

  task automatic t_dir();
    wr(7, 8, 32'h4);
    @(negedge clk_i);
    ch_dir_i = 10'h010;
    set_en(10'h36F);
    set_en('1);
    drive(10'h010, 10'h010, 10'h010); probe("R10 dir split a");
    check_eq("R5 ch4 takes rx port4", 32'(ch_req_o & 10'h010), 32'h010);
    drive(10'h010, 10'h000, 10'h080); probe("R10 dir split b");
    check_eq("R10 tx port4 to ch7", 32'(tx_ack_o), 32'h010);
    drive(10'h3FF, 10'h3FF, 10'h3FF); probe("R5 mixed load");
  endtask

  initial begin
    for (int n = 0; n < NCH; n++) begin
      m_reg[n] = n; m_sel[n] = n; m_dir[n] = 0; m_act[n] = 0;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_default();
    t_regs();
    t_latch();
    t_none();
    t_dir();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule